// File: doc/BRIEF.md
# Receive FIFO Flow-Delay and Trigger Monitor

This block watches the fill level of a receive FIFO and produces three results from it. The first is a flow-delay flag that is set when the FIFO holds at least a programmed number of entries. The second is a request-to-send (RTS) line with a four-entry hysteresis: it drops when the flag sets and comes back only once the FIFO has drained to four entries below the programmed level. The third is an RX trigger flag that an interrupt controller can use as a fill-level interrupt condition.

Two programmable 5-bit levels set the thresholds. A flow-delay level below four turns the flow-delay function off. An RX trigger level of zero turns the trigger flag off. When hardware flow control is not selected, the RTS line follows a software RTS bit. The FIFO and the serial receiver sit outside this block. Every output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `rx_flow_monitor`

## Requirements
- R1: While rst_ni is low, rts_o, flow_delay_o and rx_trig_o are all 0. RTS is active high: 1 means the receiver is ready to accept data.
- R2: When flow_delay_i is 4 or more, flow_delay_o equals (fifo_level_i >= flow_delay_i) one cycle after the inputs are sampled.
- R3: When flow_delay_i is below 4, flow_delay_o is 0 one cycle later and any RTS hold is cleared, so with hw_flow_en_i = 1 the next rts_o is 1.
- R4: With hw_flow_en_i = 1, rts_o drops to 0 in the same cycle that flow_delay_o goes to 1.
- R5: With hw_flow_en_i = 1 and RTS held low, rts_o stays 0 while fifo_level_i > flow_delay_i - 4. It returns to 1 one cycle after fifo_level_i <= flow_delay_i - 4 and fifo_level_i < flow_delay_i.
- R6: With hw_flow_en_i = 0, rts_o equals sw_rts_i one cycle later, whatever the FIFO level is.
- R7: When rx_trig_level_i is non-zero, rx_trig_o equals (fifo_level_i >= rx_trig_level_i) one cycle later.
- R8: When rx_trig_level_i is 0, rx_trig_o is 0 one cycle later, even at a full FIFO.
- R9: The RTS hold state is tracked while hw_flow_en_i is 0. If hardware mode is selected while the level is inside the hysteresis band after a trip, rts_o comes back low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_level_i | input | $clog2(FIFO_DEPTH+1) | Current receive FIFO fill level |
| flow_delay_i | input | 5 | Flow-delay level; a value below 4 disables the function |
| rx_trig_level_i | input | 5 | RX trigger level; 0 disables the flag |
| hw_flow_en_i | input | 1 | 1 selects hardware flow control of RTS |
| sw_rts_i | input | 1 | Software RTS value, used when hw_flow_en_i is 0 |
| rts_o | output | 1 | Request to send, active high |
| flow_delay_o | output | 1 | Flow-delay trigger status |
| rx_trig_o | output | 1 | RX trigger-level condition |

## Verification
Each of the three outputs is due exactly one rising edge after the inputs it depends on are sampled. Only the RTS hysteresis also depends on the history of earlier levels. The driver changes the inputs on a falling edge and pushes the expected values of that cycle into a queue. The monitor pops one entry a short delay after the next rising edge, so every comparison lands in the cycle where the registered result first appears. The expected RTS hold state is kept by a small model written from R2 to R5, independent of the RTL.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int unsigned CFG_W    = 5;
  localparam int unsigned HYST_GAP = 4;
  localparam int unsigned FDEL_MIN = 4;
endpackage

// File: rtl/rxfc_fdel_unit.sv
module rxfc_fdel_unit
  import rxfc_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [CFG_W-1:0] fdel_i,
  output logic             flag_o,
  output logic             hold_o
);
  logic        enable;
  logic        trip;
  logic        above_band;
  logic        hold_n;
  logic [31:0] lvl32, fdel32;

  assign lvl32      = 32'(level_i);
  assign fdel32     = 32'(fdel_i);
  assign enable     = fdel32 >= FDEL_MIN;
  assign trip       = enable && (lvl32 >= fdel32);
  // release point sits HYST_GAP entries under the trip level
  assign above_band = enable && (lvl32 + HYST_GAP > fdel32);
  assign hold_n     = trip || (hold_o && above_band);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      flag_o <= trip;
      hold_o <= hold_n;
    end
  end

  assert_fdel_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(fdel_i) < FDEL_MIN) |=> (!flag_o && !hold_o));

  assert_fdel_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(fdel_i) >= FDEL_MIN && 32'(level_i) >= 32'(fdel_i)) |=> flag_o);

  assert_flag_implies_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> hold_o);
endmodule

// File: rtl/rxfc_trig_unit.sv
module rxfc_trig_unit
  import rxfc_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [CFG_W-1:0] trig_i,
  output logic             trig_o
);
  logic hit;
  assign hit = (trig_i != '0) && (32'(level_i) >= 32'(trig_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_o <= 1'b0;
    else         trig_o <= hit;
  end

  assert_trig_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i == '0) |=> !trig_o);

  assert_trig_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(level_i) < 32'(trig_i)) |=> !trig_o);
endmodule

// File: rtl/rxfc_rts_unit.sv
module rxfc_rts_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_en_i,
  input  logic sw_rts_i,
  input  logic hold_i,
  output logic rts_o
);
  logic hw_q, sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q <= 1'b0;
      sw_q <= 1'b0;
    end else begin
      hw_q <= hw_en_i;
      sw_q <= sw_rts_i;
    end
  end

  assign rts_o = hw_q ? ~hold_i : sw_q;

  assert_sw_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_en_i |=> (rts_o == $past(sw_rts_i)));
endmodule

// File: rtl/rx_flow_monitor.sv
module rx_flow_monitor
  import rxfc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [CFG_W-1:0] flow_delay_i,
  input  logic [CFG_W-1:0] rx_trig_level_i,
  input  logic             hw_flow_en_i,
  input  logic             sw_rts_i,
  output logic             rts_o,
  output logic             flow_delay_o,
  output logic             rx_trig_o
);
  logic hold;

  rxfc_fdel_unit #(.LVL_W(LVL_W)) u_fdel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(fifo_level_i),
    .fdel_i (flow_delay_i),
    .flag_o (flow_delay_o),
    .hold_o (hold)
  );

  rxfc_trig_unit #(.LVL_W(LVL_W)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(fifo_level_i),
    .trig_i (rx_trig_level_i),
    .trig_o (rx_trig_o)
  );

  rxfc_rts_unit u_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_en_i (hw_flow_en_i),
    .sw_rts_i(sw_rts_i),
    .hold_i  (hold),
    .rts_o   (rts_o)
  );

  assert_rts_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_flow_en_i && 32'(flow_delay_i) >= FDEL_MIN &&
     32'(fifo_level_i) >= 32'(flow_delay_i)) |=> (!rts_o && flow_delay_o));

  assert_rts_band_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_flow_en_i && !rts_o && $past(hw_flow_en_i) && 32'(flow_delay_i) >= FDEL_MIN &&
     32'(fifo_level_i) + HYST_GAP > 32'(flow_delay_i)) |=> !rts_o);

  assert_rts_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_flow_en_i && 32'(flow_delay_i) < FDEL_MIN) |=> rts_o);
endmodule

// File: tb/tb_rx_flow_monitor.sv
module tb_rx_flow_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [LVL_W-1:0] fifo_level_i = '0;
  logic [4:0] flow_delay_i = '0;
  logic [4:0] rx_trig_level_i = '0;
  logic hw_flow_en_i = 1'b0;
  logic sw_rts_i = 1'b0;
  logic rts_o, flow_delay_o, rx_trig_o;

  int errors = 0;
  int checks = 0;
  bit m_hold = 1'b0;

  bit    q_rts[$];
  bit    q_fd[$];
  bit    q_tr[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_flow_monitor dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_level_i(fifo_level_i),
    .flow_delay_i(flow_delay_i), .rx_trig_level_i(rx_trig_level_i),
    .hw_flow_en_i(hw_flow_en_i), .sw_rts_i(sw_rts_i),
    .rts_o(rts_o), .flow_delay_o(flow_delay_o), .rx_trig_o(rx_trig_o)
  );

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // driver: apply inputs on a falling edge, push expected outputs for next rise
  task automatic apply(int lvl, int fd, int tr, bit hw, bit sw, string tag);
    bit en, trip, hold_n, exp_rts, exp_tr;
    @(negedge clk_i);
    fifo_level_i = LVL_W'(lvl);
    flow_delay_i = 5'(fd);
    rx_trig_level_i = 5'(tr);
    hw_flow_en_i = hw;
    sw_rts_i = sw;
    en = (fd >= 4);
    trip = en && (lvl >= fd);
    hold_n = trip || (m_hold && en && (lvl > fd - 4));
    m_hold = hold_n;
    exp_rts = hw ? !hold_n : sw;
    exp_tr = (tr != 0) && (lvl >= tr);
    q_rts.push_back(exp_rts);
    q_fd.push_back(trip);
    q_tr.push_back(exp_tr);
    q_tag.push_back(tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      check(t, "rts_o", rts_o, q_rts.pop_front());
      check(t, "flow_delay_o", flow_delay_o, q_fd.pop_front());
      check(t, "rx_trig_o", rx_trig_o, q_tr.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fifo_level_i = 6'd31; flow_delay_i = 5'd8; rx_trig_level_i = 5'd1;
    hw_flow_en_i = 1'b1; sw_rts_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", "rts_o", rts_o, 1'b0);
    check("R1", "flow_delay_o", flow_delay_o, 1'b0);
    check("R1", "rx_trig_o", rx_trig_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6: software mode follows sw bit even when the FIFO trips
    apply(0, 16, 0, 1'b0, 1'b1, "R6");
    apply(0, 16, 0, 1'b0, 1'b0, "R6");
    apply(20, 16, 0, 1'b0, 1'b1, "R6_R2");
    apply(3, 16, 0, 1'b0, 1'b1, "R6");

    // R2/R4/R5: hardware mode, level 16, release at 12
    apply(10, 16, 0, 1'b1, 1'b0, "R2");
    apply(15, 16, 0, 1'b1, 1'b0, "R2");
    apply(16, 16, 0, 1'b1, 1'b0, "R4");
    apply(17, 16, 0, 1'b1, 1'b0, "R4");
    apply(15, 16, 0, 1'b1, 1'b0, "R5");
    apply(13, 16, 0, 1'b1, 1'b0, "R5");
    apply(12, 16, 0, 1'b1, 1'b0, "R5");
    apply(14, 16, 0, 1'b1, 1'b0, "R5");
    apply(16, 16, 0, 1'b1, 1'b0, "R4");

    // R3: disabling clears the hold
    apply(20, 3, 0, 1'b1, 1'b0, "R3");
    apply(31, 0, 0, 1'b1, 1'b0, "R3");
    // boundary: level 4 trips, release only at 0
    apply(4, 4, 0, 1'b1, 1'b0, "R2");
    apply(1, 4, 0, 1'b1, 1'b0, "R5");
    apply(0, 4, 0, 1'b1, 1'b0, "R5");
    // top of range
    apply(31, 31, 0, 1'b1, 1'b0, "R2");
    apply(32, 31, 0, 1'b1, 1'b0, "R4");
    apply(28, 31, 0, 1'b1, 1'b0, "R5");
    apply(27, 31, 0, 1'b1, 1'b0, "R5");

    // R9: hold tracked in software mode
    apply(20, 16, 0, 1'b0, 1'b1, "R9");
    apply(14, 16, 0, 1'b0, 1'b1, "R9");
    apply(14, 16, 0, 1'b1, 1'b1, "R9");
    apply(12, 16, 0, 1'b1, 1'b1, "R9");

    // R7/R8: trigger flag
    apply(7, 0, 8, 1'b0, 1'b0, "R7");
    apply(8, 0, 8, 1'b0, 1'b0, "R7");
    apply(9, 0, 8, 1'b0, 1'b0, "R7");
    apply(0, 0, 1, 1'b0, 1'b0, "R7");
    apply(1, 0, 1, 1'b0, 1'b0, "R7");
    apply(32, 0, 31, 1'b0, 1'b0, "R7");
    apply(32, 0, 0, 1'b0, 1'b0, "R8");
    apply(5, 0, 0, 1'b0, 1'b0, "R8");

    // sweep: full level ramp up and down at several settings
    for (int fd = 2; fd < 32; fd += 7) begin
      for (int l = 0; l <= 32; l++) apply(l, fd, fd ^ 5, 1'b1, 1'b0, "R5_sweep");
      for (int l = 32; l >= 0; l--) apply(l, fd, fd ^ 5, 1'b1, 1'b0, "R5_sweep");
    end

    @(negedge clk_i);
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule